// File: doc/BRIEF.md
# Programmable-Tap Pseudorandom Bit Source

This block is a 16-bit shift-register pseudorandom generator whose feedback taps are set by a mask that can change at run time. On each advance, the mask is ANDed with the current state and the result is reduced to one bit by parity. The state then moves one place toward the most significant bit, and that parity bit enters at bit 0. A consumer can load a fresh starting value at any time. The register is kept out of the all-zero lock-up state: any zero value that would be stored is replaced by one.

The block presents three outputs. The whole state word is available to any logic that needs a random byte or index. The top state bit is brought out as a single-wire randomness monitor. A separate strobe marks one cycle in every sixteen. Byte windows cut from this register overlap heavily from one cycle to the next, and a consumer that only takes a sample on the strobe sees windows far enough apart to lose the short-lag correlation. A stride of eight is not enough to do this. The choice of mask sets the period: some masks give the full 65535-state cycle and others fall into short loops.

Top module: `prng_tap16`

## Requirements
- R1: While the active-low reset is asserted (asynchronously), the state is 0x0001, the monitor is 0 and the sample strobe is 0.
- R2: When advancing, the next state is the current state shifted up by one place, truncated to 16 bits, with bit 0 set to the parity (XOR reduction) of the current state ANDed with the tap mask.
- R3: With the advance enable low and no load request, the state does not change.
- R4: A load request writes the load value into the state at the next clock edge, whatever the enable, and takes priority over advancing.
- R5: A load value of zero is stored as 0x0001.
- R6: The state never holds zero. An advance whose result would be zero (for example state 0x8000 with mask 0x0000) stores 0x0001 instead.
- R7: With tap mask 0xB400 or 0xD008 and start value 0x0001, the state first returns to its start value after exactly 65535 advances.
- R8: With tap mask 0x002D, starting from 0x0001, the sequence enters a loop of exactly 63 states after a short transient of at most 16 advances.
- R9: The monitor output always equals state bit 15.
- R10: The sample strobe comes from a counter that runs freely from reset, independent of enable and load. It is high for exactly one cycle in every 16, first in the cycle after the 15th clock edge following reset release.
- R11: A change to the tap mask takes effect on the very next advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| advance | input | 1 | Step the generator on this edge |
| load | input | 1 | Load the start value on this edge (priority) |
| load_value | input | 16 | Start value to load |
| tap_mask | input | 16 | Feedback tap mask |
| state | output | 16 | Current generator state |
| monitor | output | 1 | Randomness monitor (state MSB) |
| sample_strobe | output | 1 | One-in-sixteen subsample marker |

## Verification
The bench goes after the lock-up corners. These are a zero load value and a shift that would leave zero, such as 0x8000 with an empty mask. A design that skipped recovery there would freeze at zero forever. It also drives load and advance in the same cycle: a design with the wrong priority would store a shifted value instead of the load value. The bench measures the full period for two maximal masks and the 63-state loop for 0x002D; a tap or shift-direction error would change these counts. It also checks the exact cycles of the strobe while enable toggles, which catches a counter that is gated by enable or that is off by one.

// File: rtl/prng_pkg.sv
package prng_pkg;
   localparam int unsigned PRNG_WIDTH_DEFAULT  = 16;
   localparam int unsigned PRNG_STRIDE_LOG2    = 4;

   typedef enum logic [1:0] {
      SRC_HOLD  = 2'd0,
      SRC_LOAD  = 2'd1,
      SRC_SHIFT = 2'd2
   } prng_src_e;
endpackage

// File: rtl/prng_tap_parity.sv
module prng_tap_parity #(
   parameter int unsigned W = 16
) (
   input  logic [W-1:0] cur,
   input  logic [W-1:0] mask,
   output logic         fb
);
   if (W < 2) begin : g_bad_width
      $error("prng_tap_parity: W must be at least 2");
   end

   logic [W-1:0] chain;

   assign chain[0] = cur[0] & mask[0];
   for (genvar i = 1; i < W; i++) begin : g_chain
      assign chain[i] = chain[i-1] ^ (cur[i] & mask[i]);
   end

   assign fb = chain[W-1];
endmodule

// File: rtl/prng_state_reg.sv
module prng_state_reg
   import prng_pkg::*;
#(
   parameter int unsigned W          = 16,
   parameter logic [W-1:0] INIT_VAL  = 1,
   parameter logic [W-1:0] ZERO_FILL = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         advance,
   input  logic         load,
   input  logic [W-1:0] load_value,
   input  logic         fb,
   output logic [W-1:0] state_q
);
   if (INIT_VAL == '0) begin : g_bad_init
      $error("prng_state_reg: INIT_VAL must be nonzero");
   end
   if (ZERO_FILL == '0) begin : g_bad_fill
      $error("prng_state_reg: ZERO_FILL must be nonzero");
   end

   prng_src_e    src;
   logic [W-1:0] candidate;
   logic [W-1:0] next_val;

   always_comb begin
      if (load)         src = SRC_LOAD;
      else if (advance) src = SRC_SHIFT;
      else              src = SRC_HOLD;
   end

   always_comb begin
      case (src)
         SRC_LOAD:  candidate = load_value;
         SRC_SHIFT: candidate = {state_q[W-2:0], fb};
         default:   candidate = state_q;
      endcase
      next_val = (candidate == '0) ? ZERO_FILL : candidate;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= INIT_VAL;
      else        state_q <= next_val;
   end

   AST_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      state_q != '0);  // R6

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!advance && !load) |=> $stable(state_q));  // R3

   AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> state_q == (($past(load_value) == '0) ? ZERO_FILL : $past(load_value)));  // R4

   AST_SHIFT_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !load) |=> state_q[W-1:1] == $past(state_q[W-2:0]));  // R2
endmodule

// File: rtl/prng_stride_gen.sv
module prng_stride_gen #(
   parameter int unsigned LOG2 = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic strobe
);
   if (LOG2 < 1) begin : g_bad_stride
      $error("prng_stride_gen: LOG2 must be at least 1");
   end

   localparam logic [LOG2-1:0] LAST = '1;

   logic [LOG2-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_q + 1'b1;
   end

   assign strobe = (cnt_q == LAST);

   AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |=> !strobe);  // R10
endmodule

// File: rtl/prng_tap16.sv
module prng_tap16
   import prng_pkg::*;
#(
   parameter int unsigned  W           = PRNG_WIDTH_DEFAULT,
   parameter int unsigned  STRIDE_LOG2 = PRNG_STRIDE_LOG2,
   parameter logic [W-1:0] INIT_VAL    = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         advance,
   input  logic         load,
   input  logic [W-1:0] load_value,
   input  logic [W-1:0] tap_mask,
   output logic [W-1:0] state,
   output logic         monitor,
   output logic         sample_strobe
);
   logic fb;

   prng_tap_parity #(.W(W)) u_parity (
      .cur  (state),
      .mask (tap_mask),
      .fb   (fb)
   );

   prng_state_reg #(.W(W), .INIT_VAL(INIT_VAL), .ZERO_FILL(W'(1))) u_state (
      .clk        (clk),
      .rst_n      (rst_n),
      .advance    (advance),
      .load       (load),
      .load_value (load_value),
      .fb         (fb),
      .state_q    (state)
   );

   prng_stride_gen #(.LOG2(STRIDE_LOG2)) u_stride (
      .clk    (clk),
      .rst_n  (rst_n),
      .strobe (sample_strobe)
   );

   assign monitor = state[W-1];

   AST_FB_ENTERS_LSB: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !load && ({state[W-2:0], fb} != '0)) |=> state[0] == $past(fb));  // R2
endmodule

// File: tb/tb_prng_tap16.sv
module tb_prng_tap16;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        advance = 1'b0;
   logic        load = 1'b0;
   logic [15:0] load_value = '0;
   logic [15:0] tap_mask = '0;
   logic [15:0] state;
   logic        monitor;
   logic        sample_strobe;

   int checks = 0;
   int failures = 0;
   int cycles = 0;

   prng_tap16 dut (
      .clk(clk), .rst_n(rst_n), .advance(advance), .load(load),
      .load_value(load_value), .tap_mask(tap_mask),
      .state(state), .monitor(monitor), .sample_strobe(sample_strobe)
   );

   always #2.5 clk = ~clk;

   // vector: start value, tap mask, expected state after one advance
   localparam logic [47:0] VEC [8] = '{
      {16'h0001, 16'hB400, 16'h0002},
      {16'h8000, 16'hB400, 16'h0001},
      {16'hFFFF, 16'hB400, 16'hFFFE},
      {16'h1234, 16'hD008, 16'h2469},
      {16'h8000, 16'h0000, 16'h0001},
      {16'h00FF, 16'h002D, 16'h01FE},
      {16'hA5A5, 16'hFFFF, 16'h4B4A},
      {16'h7001, 16'h7000, 16'hE003}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 190000) begin
         failures++;
         $display("FAIL watchdog actual=%0d expected=<190000", cycles);
         finish_run();
      end
   end

   task automatic do_load(input logic [15:0] v);
      @(negedge clk);
      load = 1'b1; load_value = v; advance = 1'b0;
      @(negedge clk);
      load = 1'b0;
   endtask

   task automatic measure_period(input logic [15:0] mask, input int skip,
                                 input int limit, output int period);
      logic [15:0] start;
      tap_mask = mask;
      do_load(16'h0001);
      advance = 1'b1;
      for (int i = 0; i < skip; i++) @(negedge clk);
      start = state;
      period = 0;
      for (int i = 0; i < limit; i++) begin
         @(negedge clk);
         period++;
         if (state == start) break;
      end
      advance = 1'b0;
   endtask

   initial begin
      int p;
      // R1 reset state
      #12;
      chk("R1 state", state, 16'h0001);
      chk("R1 monitor", monitor, 1'b0);
      chk("R1 strobe", sample_strobe, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;

      // R2 R9 R11 vector table
      foreach (VEC[k]) begin
         do_load(VEC[k][47:32]);
         chk("R4 load", state, VEC[k][47:32]);
         tap_mask = VEC[k][31:16];
         advance = 1'b1;
         @(negedge clk);
         advance = 1'b0;
         chk("R2 R6 R11 next", state, VEC[k][15:0]);
         chk("R9 monitor", monitor, VEC[k][15]);
      end

      // R3 hold with advance low
      do_load(16'hC3A5);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk("R3 hold", state, 16'hC3A5);
      end
      chk("R9 monitor high", monitor, 1'b1);

      // R4 load beats advance
      @(negedge clk);
      tap_mask = 16'hB400; load_value = 16'h5555; load = 1'b1; advance = 1'b1;
      @(negedge clk);
      load = 1'b0; advance = 1'b0;
      chk("R4 priority", state, 16'h5555);

      // R5 zero load value
      do_load(16'h0000);
      chk("R5 zero load", state, 16'h0001);

      // R6 zero result from shift
      do_load(16'h8000);
      tap_mask = 16'h0000; advance = 1'b1;
      @(negedge clk);
      chk("R6 zero shift", state, 16'h0001);
      @(negedge clk);
      advance = 1'b0;
      chk("R6 keeps running", state, 16'h0002);

      // R10 strobe timing after a fresh reset, enable toggling
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R10 strobe in reset", sample_strobe, 1'b0);
      rst_n = 1'b1;
      for (int i = 1; i <= 48; i++) begin
         advance = i[1];
         load = (i % 7 == 0);
         @(negedge clk);
         chk("R10 strobe", sample_strobe, ((i % 16) == 15));
      end
      advance = 1'b0; load = 1'b0;

      // R7 full period for two masks
      measure_period(16'hB400, 0, 70000, p);
      chk("R7 period B400", p, 65535);
      measure_period(16'hD008, 0, 70000, p);
      chk("R7 period D008", p, 65535);

      // R8 short loop for 0x002D
      measure_period(16'h002D, 16, 200, p);
      chk("R8 short loop", p, 63);

      finish_run();
   end
endmodule